// File: doc/BRIEF.md
# DMA Channel Status and Descriptor Chain Controller

This block holds the control and status state for each channel of a descriptor-based DMA engine. Each channel has a mode register that starts a transfer and selects between direct mode (one segment) and chained mode. It also has a current-descriptor register, a next-descriptor register, and a status register. The status register carries write-one-to-clear event flags and a read-only busy flag. The logic that moves data reports three kinds of event per channel: a segment finished, a local memory error, or a bus error. The logic that fetches descriptors writes the next-descriptor word into the block.

When a segment finishes in chained mode and the terminate flag of the next-descriptor word is clear, the channel copies the next address into its current-descriptor register and stays busy. In every other case a finished segment ends the transfer. An error stops the channel at once.

Each channel drives one interrupt line. The line is the OR of its pending flags. The error flags count only when the channel's error-interrupt enable is set. The line stays high until software clears the flags.

Top module: `dma_cs_top`

## Requirements
- R1: After reset every register of every channel reads 0, and `busy` and `irq` are 0.
- R2: Status register layout: bit 7 is the memory-error flag, bit 4 the bus-error flag, bit 2 busy (read-only), bit 1 the segment-done flag, and bit 0 the transfer-done flag. All other bits read 0 whatever is written.
- R3: Writing the mode register with bit 0 = 1 while the channel is idle sets busy on the next clock. While the channel is busy, a write with bit 0 = 1 does not start anything. Bit 0 always reads 0.
- R4: In chained mode (mode bit 1 = 1), a segment-done while busy with next-descriptor bit 0 = 0 loads next-descriptor bits 31:5 into current-descriptor bits 31:5. It keeps the current register's low control bits, and busy stays 1.
- R5: A segment-done while busy ends the transfer when the channel is in direct mode or next-descriptor bit 0 = 1. Busy clears, and status bit 0 is set only if mode bit 3 (transfer-done interrupt enable) = 1.
- R6: Status bit 1 is set on every segment-done while busy, the last one included, exactly when current-descriptor bit 3 = 1.
- R7: `mem_err` or `bus_err` while busy sets status bit 7 or bit 4, clears busy at once, sets neither bit 0 nor bit 1, and leaves the descriptor registers unchanged, even when a segment-done arrives in the same cycle. Errors and segment-done pulses on an idle channel are ignored.
- R8: Writing 1 to status bit 7, 4, 1 or 0 clears it, and writing 0 leaves it as it is. A hardware set in the same cycle as a clear wins.
- R9: `irq` = (mode bit 2 AND (status bit 7 OR bit 4)) OR status bit 1 OR status bit 0. It stays high until the flags are cleared or the enable is dropped.
- R10: Channel c's registers sit at (c+1)*0x100: mode at +0x0, status at +0x4, current descriptor at +0x8, next descriptor at +0xC. Mode keeps bits 3:1, current keeps bits 31:5 and 3, and next keeps bits 31:5 and 0. Writes to the current register while busy are ignored. Unmapped addresses read 0 and writes to them change nothing.
- R11: `nd_load[c]` loads channel c's next-descriptor register from its slice of `nd_word`. It wins over a software write to that register in the same cycle.
- R12: Each channel's events, registers and outputs are independent of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| seg_done | input | NUM_CH | Segment finished, one bit per channel |
| mem_err | input | NUM_CH | Local memory error during transfer |
| bus_err | input | NUM_CH | Bus abort or read parity error during transfer |
| nd_load | input | NUM_CH | Load the next-descriptor word for a channel |
| nd_word | input | 32*NUM_CH | Next-descriptor words, channel c at bits 32c+31:32c |
| busy | output | NUM_CH | Channel busy |
| irq | output | NUM_CH | Per-channel interrupt |

## Verification
The bench builds the block with NUM_CH = 3 and ADDR_W = 12. This puts a channel behind the two-channel default and places an unmapped block at 0x400 inside the address space, so the decode of the last channel and of the first invalid block are both reached. With three channels, a segment-done pulse can go to an idle channel while a neighbour is busy, which tests the independence between channels. A long random phase mixes writes, loads and events in the same cycles, so set-versus-clear and error-versus-segment collisions occur repeatedly.

// File: rtl/dma_cs_pkg.sv
package dma_cs_pkg;

  localparam int REG_W     = 32;
  localparam int BLK_SHIFT = 8;

  // register offsets inside a channel block
  localparam logic [BLK_SHIFT-1:0] OFS_MODE = 8'h00;
  localparam logic [BLK_SHIFT-1:0] OFS_STAT = 8'h04;
  localparam logic [BLK_SHIFT-1:0] OFS_CUR  = 8'h08;
  localparam logic [BLK_SHIFT-1:0] OFS_NEXT = 8'h0C;

  // mode register bits
  localparam int MODE_GO    = 0;
  localparam int MODE_CHAIN = 1;
  localparam int MODE_ERRIE = 2;
  localparam int MODE_ENDIE = 3;

  // status register bits
  localparam int ST_LMEM   = 7;
  localparam int ST_BUSERR = 4;
  localparam int ST_BUSY   = 2;
  localparam int ST_SEG    = 1;
  localparam int ST_END    = 0;

  localparam int CUR_SEGIE = 3;
  localparam int NEXT_LAST = 0;

  localparam logic [REG_W-1:0] MODE_KEEP  = 32'h0000_000E;
  localparam logic [REG_W-1:0] STAT_W1C   = 32'h0000_0093;
  localparam logic [REG_W-1:0] STAT_ERRS  = 32'h0000_0090;
  localparam logic [REG_W-1:0] STAT_DONES = 32'h0000_0003;
  localparam logic [REG_W-1:0] CUR_KEEP   = 32'hFFFF_FFE8;
  localparam logic [REG_W-1:0] NEXT_KEEP  = 32'hFFFF_FFE1;
  localparam logic [REG_W-1:0] ADDR_FIELD = 32'hFFFF_FFE0;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CUR  = 2'd2,
    SEL_NEXT = 2'd3
  } reg_sel_e;

  // chain step: address field from the next word, control bits stay
  function automatic logic [REG_W-1:0] advance_cur(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] nxt);
    return (nxt & ADDR_FIELD) | (cur & ~ADDR_FIELD & CUR_KEEP);
  endfunction

  // write-one-to-clear with hardware set taking priority
  function automatic logic [REG_W-1:0] w1c_update(input logic [REG_W-1:0] old,
                                                  input logic [REG_W-1:0] wdata,
                                                  input logic             clr_en,
                                                  input logic [REG_W-1:0] set_vec);
    logic [REG_W-1:0] clr;
    clr = clr_en ? wdata : '0;
    return ((old & ~clr) | set_vec) & STAT_W1C;
  endfunction

  function automatic logic [REG_W-1:0] stat_view(input logic [REG_W-1:0] flags,
                                                 input logic             bsy);
    logic [REG_W-1:0] v;
    v = flags & STAT_W1C;
    v[ST_BUSY] = bsy;
    return v;
  endfunction

  function automatic logic irq_of(input logic [REG_W-1:0] flags,
                                  input logic             err_en);
    return (err_en & (|(flags & STAT_ERRS))) | (|(flags & STAT_DONES));
  endfunction

endpackage

// File: rtl/dma_cs_regdec.sv
module dma_cs_regdec
  import dma_cs_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 12,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  output logic [NUM_CH-1:0] wr_mode,
  output logic [NUM_CH-1:0] wr_stat,
  output logic [NUM_CH-1:0] wr_cur,
  output logic [NUM_CH-1:0] wr_next,
  output logic              rd_hit,
  output logic [IDX_W-1:0]  rd_ch,
  output reg_sel_e          rd_sel
);

  localparam int BLK_W = ADDR_W - BLK_SHIFT;

  logic [BLK_W-1:0]     blk;
  logic [BLK_SHIFT-1:0] ofs;
  int                   blk_i;
  logic                 ofs_ok;

  assign blk   = reg_addr[ADDR_W-1:BLK_SHIFT];
  assign ofs   = reg_addr[BLK_SHIFT-1:0];
  assign blk_i = int'(blk);

  always_comb begin
    ofs_ok = 1'b1;
    rd_sel = SEL_MODE;
    case (ofs)
      OFS_MODE: rd_sel = SEL_MODE;
      OFS_STAT: rd_sel = SEL_STAT;
      OFS_CUR:  rd_sel = SEL_CUR;
      OFS_NEXT: rd_sel = SEL_NEXT;
      default:  ofs_ok = 1'b0;
    endcase
  end

  assign rd_hit = ofs_ok && (blk_i >= 1) && (blk_i <= NUM_CH);
  assign rd_ch  = IDX_W'(blk_i - 1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
    logic mine;
    assign mine       = reg_wr && rd_hit && (blk_i == c + 1);
    assign wr_mode[c] = mine && (rd_sel == SEL_MODE);
    assign wr_stat[c] = mine && (rd_sel == SEL_STAT);
    assign wr_cur[c]  = mine && (rd_sel == SEL_CUR);
    assign wr_next[c] = mine && (rd_sel == SEL_NEXT);
  end

endmodule

// File: rtl/dma_cs_channel.sv
module dma_cs_channel
  import dma_cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mode,
  input  logic             wr_stat,
  input  logic             wr_cur,
  input  logic             wr_next,
  input  logic [REG_W-1:0] wdata,
  input  logic             seg_done,
  input  logic             mem_err,
  input  logic             bus_err,
  input  logic             nd_load,
  input  logic [REG_W-1:0] nd_word,
  output logic [REG_W-1:0] mode_rd,
  output logic [REG_W-1:0] stat_rd,
  output logic [REG_W-1:0] cur_rd,
  output logic [REG_W-1:0] next_rd,
  output logic             busy,
  output logic             irq,
  output logic             start_evt,
  output logic             adv_evt,
  output logic             end_evt,
  output logic             err_evt
);

  logic [REG_W-1:0] mode_q, flags_q, cur_q, next_q;
  logic             busy_q;
  logic             seg_ok, is_last;
  logic [REG_W-1:0] set_vec;

  // events seen by this channel in the current cycle
  assign err_evt   = busy_q & (mem_err | bus_err);
  assign seg_ok    = busy_q & seg_done & ~err_evt;
  assign is_last   = ~mode_q[MODE_CHAIN] | next_q[NEXT_LAST];
  assign start_evt = wr_mode & wdata[MODE_GO] & ~busy_q;
  assign adv_evt   = seg_ok & ~is_last;
  assign end_evt   = seg_ok & is_last;

  always_comb begin
    set_vec            = '0;
    set_vec[ST_LMEM]   = busy_q & mem_err;
    set_vec[ST_BUSERR] = busy_q & bus_err;
    set_vec[ST_SEG]    = seg_ok & cur_q[CUR_SEGIE];
    set_vec[ST_END]    = end_evt & mode_q[MODE_ENDIE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      flags_q <= '0;
      cur_q   <= '0;
      next_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wdata & MODE_KEEP;
      flags_q <= w1c_update(flags_q, wdata, wr_stat, set_vec);
      if (err_evt || end_evt) busy_q <= 1'b0;
      else if (start_evt)     busy_q <= 1'b1;
      if (adv_evt)                 cur_q <= advance_cur(cur_q, next_q);
      else if (wr_cur && !busy_q)  cur_q <= wdata & CUR_KEEP;
      if (nd_load)                 next_q <= nd_word & NEXT_KEEP;
      else if (wr_next)            next_q <= wdata & NEXT_KEEP;
    end
  end

  assign mode_rd = mode_q;
  assign stat_rd = stat_view(flags_q, busy_q);
  assign cur_rd  = cur_q;
  assign next_rd = next_q;
  assign busy    = busy_q;
  assign irq     = irq_of(flags_q, mode_q[MODE_ERRIE]);

endmodule

// File: rtl/dma_cs_rdmux.sv
module dma_cs_rdmux
  import dma_cs_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    rd_hit,
  input  logic [IDX_W-1:0]        rd_ch,
  input  reg_sel_e                rd_sel,
  input  logic [NUM_CH*REG_W-1:0] mode_flat,
  input  logic [NUM_CH*REG_W-1:0] stat_flat,
  input  logic [NUM_CH*REG_W-1:0] cur_flat,
  input  logic [NUM_CH*REG_W-1:0] next_flat,
  output logic [REG_W-1:0]        rdata
);

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (int'(rd_ch) == c) begin
          case (rd_sel)
            SEL_MODE: rdata = mode_flat[c*REG_W +: REG_W];
            SEL_STAT: rdata = stat_flat[c*REG_W +: REG_W];
            SEL_CUR:  rdata = cur_flat[c*REG_W +: REG_W];
            default:  rdata = next_flat[c*REG_W +: REG_W];
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/dma_cs_top.sv
module dma_cs_top
  import dma_cs_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic                    reg_wr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [NUM_CH-1:0]       seg_done,
  input  logic [NUM_CH-1:0]       mem_err,
  input  logic [NUM_CH-1:0]       bus_err,
  input  logic [NUM_CH-1:0]       nd_load,
  input  logic [NUM_CH*32-1:0]    nd_word,
  output logic [NUM_CH-1:0]       busy,
  output logic [NUM_CH-1:0]       irq
);

  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int FLAT_W = NUM_CH * REG_W;

  logic [NUM_CH-1:0] wr_mode, wr_stat, wr_cur, wr_next;
  logic              rd_hit;
  logic [IDX_W-1:0]  rd_ch;
  reg_sel_e          rd_sel;

  logic [FLAT_W-1:0] mode_flat, stat_flat, cur_flat, next_flat;

  // named per-channel events, observed by the bound checker
  logic [NUM_CH-1:0] start_evt, adv_evt, end_evt, err_evt;

  dma_cs_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .wr_mode  (wr_mode),
    .wr_stat  (wr_stat),
    .wr_cur   (wr_cur),
    .wr_next  (wr_next),
    .rd_hit   (rd_hit),
    .rd_ch    (rd_ch),
    .rd_sel   (rd_sel)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_cs_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_mode   (wr_mode[c]),
      .wr_stat   (wr_stat[c]),
      .wr_cur    (wr_cur[c]),
      .wr_next   (wr_next[c]),
      .wdata     (reg_wdata),
      .seg_done  (seg_done[c]),
      .mem_err   (mem_err[c]),
      .bus_err   (bus_err[c]),
      .nd_load   (nd_load[c]),
      .nd_word   (nd_word[c*REG_W +: REG_W]),
      .mode_rd   (mode_flat[c*REG_W +: REG_W]),
      .stat_rd   (stat_flat[c*REG_W +: REG_W]),
      .cur_rd    (cur_flat[c*REG_W +: REG_W]),
      .next_rd   (next_flat[c*REG_W +: REG_W]),
      .busy      (busy[c]),
      .irq       (irq[c]),
      .start_evt (start_evt[c]),
      .adv_evt   (adv_evt[c]),
      .end_evt   (end_evt[c]),
      .err_evt   (err_evt[c])
    );
  end

  dma_cs_rdmux #(.NUM_CH(NUM_CH)) u_rd (
    .rd_hit    (rd_hit),
    .rd_ch     (rd_ch),
    .rd_sel    (rd_sel),
    .mode_flat (mode_flat),
    .stat_flat (stat_flat),
    .cur_flat  (cur_flat),
    .next_flat (next_flat),
    .rdata     (reg_rdata)
  );

endmodule

// File: rtl/dma_cs_checker.sv
module dma_cs_checker #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [NUM_CH-1:0] busy,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] start_evt,
  input logic [NUM_CH-1:0] adv_evt,
  input logic [NUM_CH-1:0] end_evt,
  input logic [NUM_CH-1:0] err_evt
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_prop
    p_busy_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[c]) |-> $past(start_evt[c]));

    p_adv_keeps_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      adv_evt[c] |=> busy[c]);

    p_evt_needs_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_evt[c] || end_evt[c] || err_evt[c]) |-> busy[c]);

    p_end_goes_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      end_evt[c] |=> !busy[c]);

    p_err_goes_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt[c] |=> !busy[c]);

    p_evt_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_evt[c], adv_evt[c], end_evt[c], err_evt[c]}));

    p_irq_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[c] && !reg_wr) |=> irq[c]);
  end

endmodule

bind dma_cs_top dma_cs_checker #(.NUM_CH(NUM_CH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .busy      (busy),
  .irq       (irq),
  .start_evt (start_evt),
  .adv_evt   (adv_evt),
  .end_evt   (end_evt),
  .err_evt   (err_evt)
);

// File: tb/dma_cs_top_tb_top.sv
`timescale 1ns/1ps
module dma_cs_top_tb_top;

  localparam int NCH = 3;
  localparam int AW  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [AW-1:0]     reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NCH-1:0]    seg_done = '0, mem_err = '0, bus_err = '0, nd_load = '0;
  logic [NCH*32-1:0] nd_word = '0;
  logic [NCH-1:0]    busy, irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  dma_cs_top #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seg_done(seg_done),
    .mem_err(mem_err), .bus_err(bus_err), .nd_load(nd_load),
    .nd_word(nd_word), .busy(busy), .irq(irq)
  );

  // behavioural reference state
  logic [31:0] m_mode[NCH];
  logic [31:0] m_flag[NCH];
  logic [31:0] m_cur[NCH];
  logic [31:0] m_next[NCH];
  bit          m_busy[NCH];

  function automatic bit m_irq(int c);
    return (m_mode[c][2] && (m_flag[c][7] || m_flag[c][4])) || m_flag[c][1] || m_flag[c][0];
  endfunction

  function automatic logic [31:0] m_read(int a);
    int blk = a / 256;
    int ofs = a % 256;
    int c = blk - 1;
    if (blk < 1 || blk > NCH) return 32'h0;
    case (ofs)
      0:  return m_mode[c];
      4:  return m_flag[c] | (m_busy[c] ? 32'h4 : 32'h0);
      8:  return m_cur[c];
      12: return m_next[c];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_mode[c] = 0; m_flag[c] = 0; m_cur[c] = 0; m_next[c] = 0; m_busy[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int base;
        bit wm, ws, wc, wn, errh, segok, last;
        logic [31:0] nm, nf, nc, nn;
        bit nb;
        base = (c + 1) * 256;
        wm = reg_wr && (int'(reg_addr) == base);
        ws = reg_wr && (int'(reg_addr) == base + 4);
        wc = reg_wr && (int'(reg_addr) == base + 8);
        wn = reg_wr && (int'(reg_addr) == base + 12);
        errh  = m_busy[c] && (mem_err[c] || bus_err[c]);
        segok = m_busy[c] && seg_done[c] && !errh;
        last  = !m_mode[c][1] || m_next[c][0];
        nm = wm ? (reg_wdata & 32'hE) : m_mode[c];
        nf = ws ? (m_flag[c] & ~reg_wdata) : m_flag[c];
        if (m_busy[c] && mem_err[c]) nf[7] = 1;
        if (m_busy[c] && bus_err[c]) nf[4] = 1;
        if (segok && m_cur[c][3]) nf[1] = 1;
        if (segok && last && m_mode[c][3]) nf[0] = 1;
        nf = nf & 32'h93;
        nb = m_busy[c];
        if (errh || (segok && last)) nb = 0;
        else if (wm && reg_wdata[0]) nb = 1;
        nc = m_cur[c];
        if (segok && !last) nc = {m_next[c][31:5], m_cur[c][4:0]} & 32'hFFFF_FFE8;
        else if (wc && !m_busy[c]) nc = reg_wdata & 32'hFFFF_FFE8;
        nn = m_next[c];
        if (nd_load[c]) nn = nd_word[c*32 +: 32] & 32'hFFFF_FFE1;
        else if (wn) nn = reg_wdata & 32'hFFFF_FFE1;
        m_mode[c] = nm; m_flag[c] = nf; m_cur[c] = nc; m_next[c] = nn; m_busy[c] = nb;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of registered outputs against the model
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      for (int c = 0; c < NCH; c++) begin
        check("R3/R5/R7 busy vs model", {31'b0, busy[c]}, {31'b0, m_busy[c]});
        check("R9 irq vs model", {31'b0, irq[c]}, {31'b0, m_irq(c)});
      end
    end
  end

  task automatic drive(input bit wr, input int a, input logic [31:0] d,
                       input logic [NCH-1:0] sd, input logic [NCH-1:0] me,
                       input logic [NCH-1:0] be, input logic [NCH-1:0] nl,
                       input logic [31:0] nw);
    reg_wr = wr; reg_addr = AW'(a); reg_wdata = d;
    seg_done = sd; mem_err = me; bus_err = be; nd_load = nl;
    nd_word = {NCH{nw}};
    @(negedge clk);
    reg_wr = 0; seg_done = '0; mem_err = '0; bus_err = '0; nd_load = '0;
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    drive(1, a, d, '0, '0, '0, '0, 32'h0);
  endtask

  task automatic rd_lit(input int a, input logic [31:0] exp, input string tag);
    reg_wr = 0; reg_addr = AW'(a);
    #1;
    check(tag, reg_rdata, exp);
    check({tag, " model agrees"}, m_read(a), exp);
    @(negedge clk);
  endtask

  task automatic bit_lit(input logic v, input logic e, input string tag);
    check(tag, {31'b0, v}, {31'b0, e});
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < NCH; c++) begin
      for (int o = 0; o < 16; o += 4) rd_lit((c + 1) * 256 + o, 32'h0, "R1 reset register");
      bit_lit(busy[c], 1'b0, "R1 busy after reset");
      bit_lit(irq[c], 1'b0, "R1 irq after reset");
    end

    // chained transfer on channel 0
    wreg(16'h108, 32'h0000_1008);
    drive(0, 0, 0, '0, '0, '0, 3'b001, 32'h0000_2000);
    wreg(16'h100, 32'hF);
    rd_lit(16'h104, 32'h4, "R3 busy after start");
    rd_lit(16'h100, 32'hE, "R3 start bit reads 0");
    drive(0, 0, 0, 3'b001, '0, '0, '0, 0);
    rd_lit(16'h108, 32'h0000_2008, "R4 chain advance");
    rd_lit(16'h104, 32'h6, "R6 segment flag while busy");
    bit_lit(irq[0], 1'b1, "R9 irq on segment flag");
    drive(0, 0, 0, '0, '0, '0, 3'b001, 32'h0000_3001);
    drive(0, 0, 0, 3'b001, '0, '0, '0, 0);
    rd_lit(16'h104, 32'h3, "R5 end of chain flags");
    rd_lit(16'h108, 32'h0000_2008, "R5 current kept at end");
    bit_lit(busy[0], 1'b0, "R5 busy cleared");

    // R8 write-one-to-clear
    wreg(16'h104, 32'h0);
    rd_lit(16'h104, 32'h3, "R8 write zero no effect");
    wreg(16'h104, 32'h2);
    rd_lit(16'h104, 32'h1, "R8 clear segment flag only");
    bit_lit(irq[0], 1'b1, "R9 irq held by end flag");
    wreg(16'h104, 32'h1);
    bit_lit(irq[0], 1'b0, "R9 irq drops after clear");
    wreg(16'h100, 32'h9);
    drive(1, 16'h104, 32'h1, 3'b001, '0, '0, '0, 0);
    rd_lit(16'h104, 32'h3, "R8 set wins over clear");
    wreg(16'h104, 32'h3);

    // R7 errors on channel 1
    wreg(16'h200, 32'h5);
    drive(0, 0, 0, '0, 3'b010, '0, '0, 0);
    rd_lit(16'h204, 32'h80, "R7 memory error stops channel");
    bit_lit(irq[1], 1'b1, "R9 error irq enabled");
    drive(0, 0, 0, 3'b010, '0, 3'b010, '0, 0);
    rd_lit(16'h204, 32'h80, "R7 events ignored when idle");
    wreg(16'h200, 32'h1);
    bit_lit(irq[1], 1'b0, "R9 error irq masked");
    drive(0, 0, 0, 3'b010, '0, 3'b010, '0, 0);
    rd_lit(16'h204, 32'h90, "R7 error beats segment done");
    wreg(16'h200, 32'h4);
    bit_lit(irq[1], 1'b1, "R9 enable exposes pending error");
    wreg(16'h204, 32'hFFFF_FFFF);
    rd_lit(16'h204, 32'h0, "R2 reserved bits read zero");
    wreg(16'h200, 32'hFFFF_FFFE);
    rd_lit(16'h200, 32'hE, "R10 mode field mask");
    bit_lit(busy[1], 1'b0, "R3 no start without go bit");

    // R10 map and busy write protection on channel 2
    wreg(16'h308, 32'h0000_4444);
    rd_lit(16'h308, 32'h0000_4440, "R10 current field mask");
    wreg(16'h300, 32'h1);
    wreg(16'h308, 32'h0000_8888);
    rd_lit(16'h308, 32'h0000_4440, "R10 current locked while busy");
    wreg(16'h300, 32'h1);
    bit_lit(busy[2], 1'b1, "R3 start while busy");
    wreg(16'h010, 32'hFFFF_FFFF);
    wreg(16'h110, 32'hFFFF_FFFF);
    rd_lit(16'h010, 32'h0, "R10 unmapped low block");
    rd_lit(16'h110, 32'h0, "R10 unmapped offset");
    rd_lit(16'h400, 32'h0, "R10 block past last channel");
    rd_lit(16'h100, 32'h8, "R10 unmapped write harmless");

    // R11 hardware load beats software write
    drive(1, 16'h30C, 32'h5555, '0, '0, '0, 3'b100, 32'h7777);
    rd_lit(16'h30C, 32'h7761, "R11 load wins");
    wreg(16'h30C, 32'h5555);
    rd_lit(16'h30C, 32'h5541, "R11 software write");

    // R12 independence
    drive(0, 0, 0, 3'b101, '0, '0, '0, 0);
    bit_lit(busy[2], 1'b0, "R12 channel 2 finished");
    rd_lit(16'h304, 32'h0, "R12 channel 2 flags");
    rd_lit(16'h104, 32'h0, "R12 idle channel 0 untouched");
    rd_lit(16'h204, 32'h0, "R12 channel 1 untouched");

    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int c = $urandom % NCH;
      int o = ($urandom % 5) * 4;
      int a = ($urandom % 8 == 0) ? ($urandom % 4096) : ((c + 1) * 256 + o);
      logic [31:0] d = $urandom;
      reg_wr = ($urandom % 3 == 0);
      reg_addr = AW'(a);
      reg_wdata = d;
      for (int k = 0; k < NCH; k++) begin
        seg_done[k] = ($urandom % 5 == 0);
        mem_err[k]  = ($urandom % 23 == 0);
        bus_err[k]  = ($urandom % 23 == 0);
        nd_load[k]  = ($urandom % 6 == 0);
      end
      for (int k = 0; k < NCH; k++) nd_word[k*32 +: 32] = $urandom;
      #1;
      if (!reg_wr) check("R10 random readback vs model", reg_rdata, m_read(a));
      @(negedge clk);
    end
    reg_wr = 0; seg_done = '0; mem_err = '0; bus_err = '0; nd_load = '0;
    @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule